// File: doc/BRIEF.md
# Loadable Counter with Decade Mode

A four-bit synchronous counter with a parallel-load port and a count enable. Each cycle it picks one of four operations: clear, load, count or hold. In binary mode the operation comes from the external load and count controls. Load wins over count. The counter runs through all sixteen values and wraps from 15 to 0.

In decade mode the external load control and the data word are ignored. The load request comes from an internal detect gate, which is the AND of state bit 3 and state bit 0. The load data is tied to zero. While the gate is low, the count control still decides between increment and hold. When the gate goes high, which first happens at 1001, the next edge loads 0000. This gives the repeating sequence 0 through 9. The same gate also brings any value above nine back to zero, without the help of a modulo compare.

The controller is written as an operation selector with named states:
- `OP_CLEAR` is taken when reset is high.
- `OP_LOAD` is taken on an external load in binary mode, or on a detect hit in decade mode.
- `OP_COUNT` is taken when the count control is high and no load applies.
- `OP_HOLD` covers every other case.

Top module: `ldc_decade_counter`

## Requirements
- R1: A high `rst` on a rising edge makes `value_o` 0000 after that edge, in either mode and whatever the other inputs are.
- R2: In binary mode (`decade_i`=0), `load_i`=1 puts `data_i` into the counter on the edge, whatever the value of `count_i`.
- R3: In binary mode with `load_i`=0 and `count_i`=1, the value increments by one on each edge, and 1111 wraps to 0000.
- R4: In binary mode with `load_i`=0 and `count_i`=0, the value holds.
- R5: In decade mode (`decade_i`=1), `load_i` and `data_i` have no effect on the value.
- R6: In decade mode, when bit 3 and bit 0 of the value are both 1 (first at 1001), the next edge loads 0000, whatever the value of `count_i`.
- R7: In decade mode, while bit 3 and bit 0 are not both 1, `count_i`=1 increments the value and `count_i`=0 holds it.
- R8: In decade mode, starting from 0000 with `count_i` held at 1, the value runs 0,1,...,9,0 with a period of exactly ten clocks.
- R9: If decade mode is entered with a value above nine, the value returns to zero through the detect gate: 1011, 1101 and 1111 go straight to 0000, and 1010, 1100 and 1110 first step up by one when counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous clear, active high |
| load_i | input | 1 | Parallel-load request (binary mode only) |
| count_i | input | 1 | Count enable |
| decade_i | input | 1 | 0 = binary mode, 1 = decade mode |
| data_i | input | 4 | Parallel-load word (binary mode only) |
| value_o | output | 4 | Current counter value |

## Verification
The bench drives load and count high together, to catch a design that lets count win over load. It runs through the 1111 wrap, where a design with a wrong width or saturation would stick at 15. In decade mode it drives a live load with nonzero data at 1000 and at 1001: a design that still uses the external port would jump to that data instead of stepping to 1001 or clearing to zero. It also enters decade mode from 1011, 1100 and 1110, where a modulo compare against 9 would behave differently from the bit-3-and-bit-0 gate, and it counts the period of a long decade run so that an off-by-one wrap at 8 or 10 is exposed.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ldc_op_e;

    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_DECADE = 1'b1
    } ldc_mode_e;

endpackage

// File: rtl/ldc_detect.sv
module ldc_detect #(
    parameter int WIDTH  = 4,
    parameter int HI_BIT = 3,
    parameter int LO_BIT = 0
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             hit_o
);
    // Two-input AND on the terminal-state bits; drives the load request in decade mode.
    always_comb begin
        hit_o = value_i[HI_BIT] & value_i[LO_BIT];
    end
endmodule

// File: rtl/ldc_ctrl.sv
module ldc_ctrl
    import ldc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             rst,
    input  logic             load_i,
    input  logic             count_i,
    input  ldc_mode_e        mode_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             hit_i,
    output ldc_op_e          op_o,
    output logic [WIDTH-1:0] ld_data_o
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic load_req;

    // Select the load source and the load word for the current mode.
    always_comb begin
        unique case (mode_i)
            MODE_BINARY: begin
                load_req  = load_i;
                ld_data_o = data_i;
            end
            MODE_DECADE: begin
                load_req  = hit_i;
                ld_data_o = ZERO;
            end
            default: begin
                load_req  = 1'b0;
                ld_data_o = ZERO;
            end
        endcase
    end

    // Priority: clear, then load, then count, then hold.
    always_comb begin
        if (rst)
            op_o = OP_CLEAR;
        else if (load_req)
            op_o = OP_LOAD;
        else if (count_i)
            op_o = OP_COUNT;
        else
            op_o = OP_HOLD;
    end
endmodule

// File: rtl/ldc_reg.sv
module ldc_reg
    import ldc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ldc_op_e          op_i,
    input  logic [WIDTH-1:0] ld_data_i,
    output logic [WIDTH-1:0] value_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] value_d;

    always_comb begin
        unique case (op_i)
            OP_CLEAR: value_d = '0;
            OP_LOAD:  value_d = ld_data_i;
            OP_COUNT: value_d = value_q + ONE;
            OP_HOLD:  value_d = value_q;
            default:  value_d = value_q;
        endcase
    end

    always_ff @(posedge clk) begin
        value_q <= value_d;
    end

    always_comb begin
        value_o = value_q;
    end

    // R1: a clear request leaves zero after the edge.
    a_r1_clear: assert property (@(posedge clk)
        (op_i == OP_CLEAR) |=> (value_q == '0));

    // R2: a load request leaves the selected word after the edge.
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LOAD) |=> (value_q == $past(ld_data_i)));

    // R3: counting adds one, with modular wrap.
    a_r3_incr: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_COUNT) |=> (value_q == $past(value_q) + ONE));

    // R4: holding keeps the value.
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_HOLD) |=> $stable(value_q));
endmodule

// File: rtl/ldc_decade_counter.sv
module ldc_decade_counter
    import ldc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             count_i,
    input  logic             decade_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] value_o
);
    localparam int HI_BIT = 3;
    localparam int LO_BIT = 0;
    localparam logic [WIDTH-1:0] NINE = WIDTH'(9);

    ldc_mode_e        mode;
    ldc_op_e          op;
    logic             hit;
    logic [WIDTH-1:0] ld_data;
    logic [WIDTH-1:0] value;

    always_comb begin
        mode = decade_i ? MODE_DECADE : MODE_BINARY;
    end

    ldc_detect #(.WIDTH(WIDTH), .HI_BIT(HI_BIT), .LO_BIT(LO_BIT)) u_detect (
        .value_i (value),
        .hit_o   (hit)
    );

    ldc_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .rst       (rst),
        .load_i    (load_i),
        .count_i   (count_i),
        .mode_i    (mode),
        .data_i    (data_i),
        .hit_i     (hit),
        .op_o      (op),
        .ld_data_o (ld_data)
    );

    ldc_reg #(.WIDTH(WIDTH)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op),
        .ld_data_i (ld_data),
        .value_o   (value)
    );

    always_comb begin
        value_o = value;
    end

    // R6: in decade mode, nine is followed by zero.
    a_r6_nine_wraps: assert property (@(posedge clk) disable iff (rst)
        (decade_i && value == NINE) |=> (value == '0));

    // R6, R9: any detect hit in decade mode clears on the next edge.
    a_r9_hit_clears: assert property (@(posedge clk) disable iff (rst)
        (decade_i && value[HI_BIT] && value[LO_BIT]) |=> (value == '0));

    // R5, R7: in decade mode with no hit and count low, the external load has no effect.
    a_r5_load_ignored: assert property (@(posedge clk) disable iff (rst)
        (decade_i && !(value[HI_BIT] && value[LO_BIT]) && !count_i) |=> $stable(value));

    // R7: in decade mode with no hit and count high, the value steps by one.
    a_r7_decade_step: assert property (@(posedge clk) disable iff (rst)
        (decade_i && !(value[HI_BIT] && value[LO_BIT]) && count_i)
            |=> (value == $past(value) + WIDTH'(1)));
endmodule

// File: tb/ldc_decade_counter_bench.sv
`timescale 1ns/1ps
module ldc_decade_counter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic       count_i = 1'b0;
    logic       decade_i = 1'b0;
    logic [3:0] data_i = 4'h0;
    logic [3:0] value_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ldc_decade_counter u_ldc_decade_counter (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .count_i  (count_i),
        .decade_i (decade_i),
        .data_i   (data_i),
        .value_o  (value_o)
    );

    // Vector fields: {rst, load, count, decade, data[3:0], expected[3:0]}
    localparam int NVEC = 22;
    localparam logic [11:0] VEC [NVEC] = '{
        {4'b1000, 4'h0, 4'h0},  // R1 reset
        {4'b0100, 4'hA, 4'hA},  // R2 load, count low
        {4'b0110, 4'h3, 4'h3},  // R2 load beats count
        {4'b0010, 4'h9, 4'h4},  // R3 increment
        {4'b0000, 4'h9, 4'h4},  // R4 hold
        {4'b0100, 4'hF, 4'hF},  // R2 load 15
        {4'b0010, 4'h0, 4'h0},  // R3 wrap 15 -> 0
        {4'b0010, 4'h0, 4'h1},  // R3 increment
        {4'b1110, 4'h7, 4'h0},  // R1 reset beats load
        {4'b0100, 4'h8, 4'h8},  // R2 load 8
        {4'b0111, 4'h5, 4'h9},  // R5 R7 decade load ignored, steps to 9
        {4'b0001, 4'h0, 4'h0},  // R6 9 -> 0 with count low
        {4'b0101, 4'h6, 4'h0},  // R5 R7 load ignored, hold at 0
        {4'b0100, 4'hC, 4'hC},  // R2 binary load 12
        {4'b0011, 4'h0, 4'hD},  // R9 12 steps to 13
        {4'b0001, 4'h0, 4'h0},  // R9 13 clears
        {4'b0100, 4'hB, 4'hB},  // R2 binary load 11
        {4'b0001, 4'h0, 4'h0},  // R9 11 clears
        {4'b0100, 4'hE, 4'hE},  // R2 binary load 14
        {4'b0011, 4'h0, 4'hF},  // R9 14 steps to 15
        {4'b0111, 4'h3, 4'h0},  // R9 R6 15 clears, load ignored
        {4'b1011, 4'h0, 4'h0}   // R1 reset in decade mode
    };

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (value_o !== exp) begin
            fails++;
            $display("FAIL %s: value_o=%0d expected=%0d", req, value_o, exp);
        end
    endtask

    task automatic step(input logic r, input logic ld, input logic cn,
                        input logic dc, input logic [3:0] d);
        @(negedge clk);
        rst = r; load_i = ld; count_i = cn; decade_i = dc; data_i = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] model;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
            check($sformatf("vector %0d (R1..R9 table)", i), VEC[i][3:0]);
        end

        // R8: decade run from zero with count high, period ten
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'h0);
        check("R1 reset before decade run", 4'h0);
        for (int k = 1; k <= 30; k++) begin
            step(1'b0, 1'b1, 1'b1, 1'b1, 4'h7);
            check("R8 decade sequence", 4'(k % 10));
        end

        // R7, R6: decade with gapped count enable
        model = value_o;
        for (int k = 0; k < 24; k++) begin
            logic cn;
            cn = (k % 3) != 0;
            step(1'b0, 1'b0, cn, 1'b1, 4'h0);
            if (model[3] && model[0])
                model = 4'h0;
            else if (cn)
                model = model + 4'h1;
            check("R7 decade gated count", model);
        end

        // R9: enter decade from 10
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'hA);
        check("R2 load 10", 4'hA);
        step(1'b0, 1'b0, 1'b0, 1'b1, 4'h0);
        check("R9 10 holds with count low", 4'hA);
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'h0);
        check("R9 10 steps to 11", 4'hB);
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'h0);
        check("R9 11 clears", 4'h0);

        // R1: mid-run reset in decade mode
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'h0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'h0);
        check("R7 step to 2", 4'h2);
        step(1'b1, 1'b1, 1'b1, 1'b1, 4'hF);
        check("R1 reset mid decade run", 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule